// File: doc/BRIEF.md
# PLL Clock Ratio Sequencer

This block controls the ratio between a reference oscillator and a system clock. A clock multiplier and a post-divider are set through plain write strobes. The ratio is never produced as a real clock. Instead, the block emits a single-cycle clock-enable strobe, `sys_stb`, on a fast reference clock `clk`. Over time, the strobe rate equals the rate the system clock would have, measured as a fraction of `clk`. The oscillator is assumed to have a nominal period of `OSC_TICKS` fast ticks. The PLL itself is modelled as an ideal ratio plus a lock-time counter that counts oscillator rising edges.

The block enforces an ordering rule: the multiplier can only be changed while the divider select holds its reset value. After each accepted multiplier write, the system runs at half the oscillator rate until the lock counter expires, and only then moves to the new ratio. A watchdog counter on the oscillator input detects a stopped oscillator. When that happens, the block falls into a sticky limp mode at a fixed fallback rate. A control bit can hold off detection while the ratio is being reprogrammed. All pins are plain control and status; no data stream passes through the block, so there is no back-pressure.

Top module: `pll_ratio_seq`

## Requirements
- R1: After reset, the multiplier reads 0, the divider select reads 0, the detector-disable bit reads 0, `locked` is 1 and `limp` is 0. The strobe rate is 1 per 4*OSC_TICKS ticks.
- R2: When locked and not in limp mode, the strobe rate is M/(OSC_TICKS*D) per tick:
  - M is the multiplier value, or 1 when the multiplier is 0 (bypass).
  - D is 4 for divider select 0 or 1, 2 for select 2, and 1 for select 3.
  - Any window of OSC_TICKS*D consecutive ticks holds exactly M strobes.
- R3: A multiplier write is accepted only when the registered divider select equals 0. Otherwise the multiplier readback and `locked` are unchanged.
- R4: A multiplier write with a value above MULT_MAX (default 10) is ignored.
- R5: An accepted multiplier write, including a write of 0, drops `locked` on the next cycle. `locked` then stays 0 until LOCK_EDGES further oscillator rising edges have been seen.
- R6: While `locked` is 0 and not in limp mode, the strobe rate is 1 per 2*OSC_TICKS ticks, whatever the multiplier and divider.
- R7: With detection enabled, a gap of MISS_TICKS ticks without an oscillator rising edge sets `limp`.
  - `limp` stays set until reset, even if the oscillator resumes.
  - In limp mode the strobe rate is 1 per LIMP_TICKS ticks.
- R8: While the detector-disable bit reads 1, `limp` never rises, however long the oscillator stops.
- R9: When the divider and the multiplier are written in the same cycle, the multiplier write is judged against the divider select held before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; every cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Reference oscillator, asynchronous to clk |
| wr_mult_en | input | 1 | Write strobe for the multiplier |
| wr_mult | input | MW | Multiplier value, MW = clog2(MULT_MAX+1) |
| wr_div_en | input | 1 | Write strobe for the divider select |
| wr_div | input | 2 | Divider select value |
| wr_mcd_en | input | 1 | Write strobe for the detector-disable bit |
| wr_mcd_off | input | 1 | 1 disables missing-clock detection |
| sys_stb | output | 1 | System clock-enable strobe |
| locked | output | 1 | 1 when no lock wait is running |
| limp | output | 1 | Sticky missing-clock status |
| mult_val | output | MW | Multiplier readback |
| div_val | output | 2 | Divider select readback |
| mcd_off_val | output | 1 | Detector-disable readback |

## Verification
The bench tries multiplier writes with a nonzero divider select and with out-of-range values. A design that skipped either guard would change the readback and drop `locked`. It writes both fields in one cycle, which catches a design that checks the multiplier against the new divider value. It measures strobe counts over windows of exact period length. This exposes a wrong divider decode, a bypass that multiplies by 0, or a design that keeps the target ratio during lock instead of falling back to half rate. Finally, it stops the oscillator with detection disabled and then enabled. This catches a detector that ignores the disable bit and a limp flag that clears once the oscillator returns.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    DSEL_QUARTER_A = 2'd0,
    DSEL_QUARTER_B = 2'd1,
    DSEL_HALF      = 2'd2,
    DSEL_FULL      = 2'd3
  } dsel_e;

  typedef enum logic [1:0] {
    SRC_RUN  = 2'd0,
    SRC_LOCK = 2'd1,
    SRC_LIMP = 2'd2
  } rate_src_e;

  function automatic logic [2:0] dsel_factor(input logic [1:0] sel);
    case (sel)
      DSEL_HALF: dsel_factor = 3'd2;
      DSEL_FULL: dsel_factor = 3'd1;
      default:   dsel_factor = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_seq_pkg::*;
#(
  parameter int MULT_MAX   = 10,
  parameter int LOCK_EDGES = 4096,
  localparam int MW        = $clog2(MULT_MAX + 1),
  localparam int LW        = $clog2(LOCK_EDGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mult_en,
  input  logic [MW-1:0] wr_mult,
  input  logic          wr_div_en,
  input  logic [1:0]    wr_div,
  input  logic          wr_mcd_en,
  input  logic          wr_mcd_off,
  input  logic          osc_rise,
  output logic [MW-1:0] mult_q,
  output logic [1:0]    div_q,
  output logic          mcd_off_q,
  output logic          locked
);

  logic          mult_ok;
  logic [LW-1:0] lock_cnt;

  // judged against the divider select held before this cycle
  assign mult_ok = wr_mult_en && (div_q == DSEL_QUARTER_A) &&
                   (wr_mult <= MW'(MULT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q    <= '0;
      div_q     <= DSEL_QUARTER_A;
      mcd_off_q <= 1'b0;
    end else begin
      if (mult_ok)   mult_q    <= wr_mult;
      if (wr_div_en) div_q     <= wr_div;
      if (wr_mcd_en) mcd_off_q <= wr_mcd_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lock_cnt <= '0;
    else if (mult_ok)                    lock_cnt <= LW'(LOCK_EDGES);
    else if (osc_rise && lock_cnt != 0)  lock_cnt <= lock_cnt - 1'b1;
  end

  assign locked = (lock_cnt == '0);

endmodule

// File: rtl/pll_clk_mon.sv
module pll_clk_mon #(
  parameter int MISS_TICKS = 100,
  localparam int CW        = $clog2(MISS_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  input  logic mcd_off,
  output logic osc_rise,
  output logic limp
);

  logic [2:0]    sync_q;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], osc_in};
  end

  assign osc_rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      limp    <= 1'b0;
    end else begin
      if (osc_rise || mcd_off)            gap_cnt <= '0;
      else if (gap_cnt != CW'(MISS_TICKS)) gap_cnt <= gap_cnt + 1'b1;
      if (!mcd_off && gap_cnt == CW'(MISS_TICKS)) limp <= 1'b1;
    end
  end

endmodule

// File: rtl/pll_rate_gen.sv
module pll_rate_gen
  import pll_seq_pkg::*;
#(
  parameter int MULT_MAX   = 10,
  parameter int OSC_TICKS  = 16,
  parameter int LIMP_TICKS = 64,
  localparam int MW        = $clog2(MULT_MAX + 1),
  localparam int DEN_MAX   = (4 * OSC_TICKS > LIMP_TICKS) ? 4 * OSC_TICKS : LIMP_TICKS,
  localparam int DW        = $clog2(DEN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          limp,
  input  logic          locked,
  input  logic [MW-1:0] mult_q,
  input  logic [1:0]    div_q,
  output logic          sys_stb
);

  rate_src_e     src;
  logic [DW-1:0] num, den, num_q, den_q, acc;
  logic [DW:0]   sum;

  always_comb begin
    if (limp)         src = SRC_LIMP;
    else if (!locked) src = SRC_LOCK;
    else              src = SRC_RUN;
    case (src)
      SRC_LIMP: begin num = DW'(1); den = DW'(LIMP_TICKS);    end
      SRC_LOCK: begin num = DW'(1); den = DW'(2 * OSC_TICKS); end
      default: begin
        num = (mult_q == '0) ? DW'(1) : DW'(mult_q);
        den = DW'(OSC_TICKS) * DW'(dsel_factor(div_q));
      end
    endcase
  end

  assign sum = {1'b0, acc} + {1'b0, num};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      num_q   <= '0;
      den_q   <= '0;
      sys_stb <= 1'b0;
    end else begin
      num_q <= num;
      den_q <= den;
      if (num != num_q || den != den_q) begin
        acc     <= '0;
        sys_stb <= 1'b0;
      end else if (sum >= {1'b0, den}) begin
        acc     <= DW'(sum - {1'b0, den});
        sys_stb <= 1'b1;
      end else begin
        acc     <= DW'(sum);
        sys_stb <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pll_ratio_seq.sv
module pll_ratio_seq #(
  parameter int MULT_MAX   = 10,
  parameter int OSC_TICKS  = 16,
  parameter int LOCK_EDGES = 4096,
  parameter int MISS_TICKS = 100,
  parameter int LIMP_TICKS = 64,
  localparam int MW        = $clog2(MULT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_in,
  input  logic          wr_mult_en,
  input  logic [MW-1:0] wr_mult,
  input  logic          wr_div_en,
  input  logic [1:0]    wr_div,
  input  logic          wr_mcd_en,
  input  logic          wr_mcd_off,
  output logic          sys_stb,
  output logic          locked,
  output logic          limp,
  output logic [MW-1:0] mult_val,
  output logic [1:0]    div_val,
  output logic          mcd_off_val
);

  logic osc_rise;

  pll_cfg_regs #(.MULT_MAX(MULT_MAX), .LOCK_EDGES(LOCK_EDGES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_mult_en(wr_mult_en), .wr_mult(wr_mult),
    .wr_div_en(wr_div_en), .wr_div(wr_div),
    .wr_mcd_en(wr_mcd_en), .wr_mcd_off(wr_mcd_off),
    .osc_rise(osc_rise),
    .mult_q(mult_val), .div_q(div_val), .mcd_off_q(mcd_off_val),
    .locked(locked)
  );

  pll_clk_mon #(.MISS_TICKS(MISS_TICKS)) u_mon (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .mcd_off(mcd_off_val),
    .osc_rise(osc_rise), .limp(limp)
  );

  pll_rate_gen #(.MULT_MAX(MULT_MAX), .OSC_TICKS(OSC_TICKS), .LIMP_TICKS(LIMP_TICKS)) u_rate (
    .clk(clk), .rst_n(rst_n), .limp(limp), .locked(locked),
    .mult_q(mult_val), .div_q(div_val), .sys_stb(sys_stb)
  );

endmodule

// File: rtl/pll_ratio_seq_chk.sv
module pll_ratio_seq_chk #(
  parameter int MULT_MAX = 10,
  localparam int MW      = $clog2(MULT_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_mult_en,
  input logic [MW-1:0] wr_mult,
  input logic          locked,
  input logic          limp,
  input logic [MW-1:0] mult_val,
  input logic [1:0]    div_val,
  input logic          mcd_off_val
);

  p_guard_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mult_en && div_val != 2'd0) |=> (mult_val == $past(mult_val)));

  p_guard_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mult_en && div_val != 2'd0 && locked) |=> locked);

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mult_en && wr_mult > MW'(MULT_MAX)) |=> (mult_val == $past(mult_val)));

  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mult_en && div_val == 2'd0 && wr_mult <= MW'(MULT_MAX))
      |=> (!locked && mult_val == $past(wr_mult)));

  p_limp_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    limp |=> limp);

  p_mcd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mcd_off_val && !limp) |=> !limp);

endmodule

bind pll_ratio_seq pll_ratio_seq_chk #(.MULT_MAX(MULT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_mult_en(wr_mult_en), .wr_mult(wr_mult),
  .locked(locked), .limp(limp), .mult_val(mult_val), .div_val(div_val),
  .mcd_off_val(mcd_off_val)
);

// File: tb/sim_pll_ratio_seq.sv
`timescale 1ns/1ps
module sim_pll_ratio_seq;

  localparam int OSC  = 16;
  localparam int LOCK = 20;
  localparam int MISS = 60;
  localparam int LIMP = 50;
  localparam int MMAX = 10;

  logic clk = 1'b0, rst_n = 1'b0, osc_in = 1'b0, osc_stop = 1'b0;
  logic wr_mult_en = 0, wr_div_en = 0, wr_mcd_en = 0, wr_mcd_off = 0;
  logic [3:0] wr_mult = '0;
  logic [1:0] wr_div = '0;
  logic sys_stb, locked, limp, mcd_off_val;
  logic [3:0] mult_val;
  logic [1:0] div_val;

  int tests = 0, fails = 0, ph = 0;
  int m_mult = 0, m_div = 0;

  always #2.5 clk = ~clk;

  pll_ratio_seq #(.MULT_MAX(MMAX), .OSC_TICKS(OSC), .LOCK_EDGES(LOCK),
                  .MISS_TICKS(MISS), .LIMP_TICKS(LIMP)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
    .wr_mult_en(wr_mult_en), .wr_mult(wr_mult),
    .wr_div_en(wr_div_en), .wr_div(wr_div),
    .wr_mcd_en(wr_mcd_en), .wr_mcd_off(wr_mcd_off),
    .sys_stb(sys_stb), .locked(locked), .limp(limp),
    .mult_val(mult_val), .div_val(div_val), .mcd_off_val(mcd_off_val)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (!osc_stop) begin
        ph++;
        if (ph == OSC / 2) begin osc_in = ~osc_in; ph = 0; end
      end
    end
  end

  function automatic int dfac(input int d);
    return (d == 3) ? 1 : (d == 2) ? 2 : 4;
  endfunction
  function automatic int run_num(input int m);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit me, input int m, input bit de, input int d);
    @(negedge clk);
    wr_mult_en = me; wr_mult = 4'(m); wr_div_en = de; wr_div = 2'(d);
    @(negedge clk);
    wr_mult_en = 0; wr_div_en = 0;
  endtask

  task automatic wr_mcd(input bit v);
    @(negedge clk); wr_mcd_en = 1; wr_mcd_off = v;
    @(negedge clk); wr_mcd_en = 0;
  endtask

  task automatic measure(input int num, input int den, input string req);
    int cnt = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4 * den; i++) begin
      @(negedge clk);
      if (sys_stb) cnt++;
    end
    check(cnt == 4 * num, req, cnt, 4 * num);
  endtask

  task automatic check_regs(input string req);
    check(int'(mult_val) == m_mult, {req, " mult"}, int'(mult_val), m_mult);
    check(int'(div_val) == m_div, {req, " div"}, int'(div_val), m_div);
  endtask

  // apply a write, model its effect, follow any lock wait
  task automatic apply(input bit me, input int m, input bit de, input int d);
    bit acc;
    int t = 0;
    acc = me && (m_div == 0) && (m <= MMAX);   // R9: judged before the div write
    wr(me, m, de, d);
    if (acc) m_mult = m;
    if (de) m_div = d;
    check_regs("R3/R4/R9 readback");
    if (acc) begin
      check(locked == 1'b0, "R5 lock drop", int'(locked), 0);
      measure(1, 2 * OSC, "R6 lock fallback rate");
      while (!locked && t < 4000) begin @(negedge clk); t++; end
      t = t + 4 + 8 * OSC;
      check(t >= (LOCK - 1) * OSC && t <= (LOCK + 1) * OSC + 6, "R5 lock time", t, LOCK * OSC);
    end else begin
      check(locked == 1'b1, "R3 lock untouched", int'(locked), 1);
    end
    measure(run_num(m_mult), OSC * dfac(m_div), "R2 run rate");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mult_val == 0 && div_val == 0 && mcd_off_val == 0, "R1 regs", int'({mult_val, div_val}), 0);
    check(locked == 1 && limp == 0, "R1 status", int'({locked, limp}), 2);
    measure(1, 4 * OSC, "R1 reset rate");

    // directed: ratio 10 then divide by 2
    apply(1, 10, 0, 0);
    apply(0, 0, 1, 2);
    // R3: multiplier write blocked when divider select is nonzero
    apply(1, 3, 0, 0);
    // R9: simultaneous write, old divider select is 2 -> ignored
    apply(1, 5, 1, 0);
    // R4: out-of-range value ignored
    apply(1, 13, 0, 0);
    // R9: simultaneous write, old divider select is 0 -> accepted
    apply(1, 5, 1, 3);
    // R3: divider select 1 also blocks
    apply(0, 0, 1, 1);
    apply(1, 7, 0, 0);
    // bypass via multiplier 0 (R2, R5)
    apply(0, 0, 1, 0);
    apply(1, 0, 0, 0);

    for (int it = 0; it < 14; it++) begin
      int op = $urandom_range(0, 2);
      int m  = $urandom_range(0, 15);
      int d  = $urandom_range(0, 3);
      if (op == 0)      apply(0, 0, 1, d);
      else if (op == 1) apply(1, m, 0, 0);
      else              apply(1, m, 1, d);
    end

    // R8: detection disabled, oscillator stopped
    wr_mcd(1);
    check(mcd_off_val == 1, "R8 disable readback", int'(mcd_off_val), 1);
    osc_stop = 1;
    repeat (4 * MISS) @(negedge clk);
    check(limp == 0, "R8 no limp while disabled", int'(limp), 0);
    osc_stop = 0;
    repeat (3 * OSC) @(negedge clk);
    wr_mcd(0);
    repeat (3 * OSC) @(negedge clk);
    check(limp == 0, "R8 no limp after re-enable", int'(limp), 0);

    // R7: missing clock
    osc_stop = 1;
    repeat (20) @(negedge clk);
    check(limp == 0, "R7 no early limp", int'(limp), 0);
    repeat (MISS + OSC + 10) @(negedge clk);
    check(limp == 1, "R7 limp set", int'(limp), 1);
    measure(1, LIMP, "R7 limp rate");
    osc_stop = 0;
    repeat (6 * OSC) @(negedge clk);
    check(limp == 1, "R7 limp sticky", int'(limp), 1);

    // R1: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    m_mult = 0; m_div = 0;
    check(limp == 0 && locked == 1, "R1 status after reset", int'({locked, limp}), 2);
    check_regs("R1");
    measure(1, 4 * OSC, "R1 rate after reset");

    summary();
  end

endmodule